// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address by fetching translation entries from memory. On a miss it reads the first-level (directory) entry selected by the top ten address bits. It then either stops there, when that entry maps a 4 MB region directly, or goes on to read the second-level (table) entry selected by the next ten bits. The result is a refill record for the translation cache: the virtual page number, the physical address, the effective permissions, the global flag and the dirty state. If the walk cannot complete, the result is a fault record that gives the faulting address, the cause and the kind of access.

The walker talks to memory through a single-word request/response port. The request and its address stay asserted until a one-cycle acknowledge arrives. On a read, the data is valid in the acknowledge cycle. After a successful walk, the walker writes back the accessed flag (bit 5) of every entry it used, and the dirty flag (bit 6) of the leaf entry on a write access. Each writeback happens only when that flag was clear. The walker handles one miss at a time.

Top module: `tlb_miss_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `fill_valid` and `fault_valid` are all low, and they stay low while no miss is in progress.
- R2: The directory entry is read at `{dir_frame, va[31:22], 2'b00}`. For a small page, the table entry is read at `{dir_entry[31:12], va[21:12], 2'b00}`.
- R3: For a present, non-large directory entry and a present table entry, the result has `fill_pa = {tbl_entry[31:12], va[11:0]}`, `fill_vpn = va[31:12]` and `fill_large = 0`.
- R4: A present directory entry with bit 7 set is a 4 MB leaf. The result has `fill_pa = {dir_entry[31:22], va[21:0]}` and `fill_large = 1`, and no second-level read is made.
- R5: If bit 0 (present) is clear in either entry, the walk ends with `fault_valid`, `fault_prot = 0`, the faulting address on `fault_va`, and the access type on `fault_write` and `fault_user`. No further memory access is made.
- R6: Bit 1 (writable) and bit 2 (user) are ANDed across both levels. A write needs the effective writable flag, and a user access needs the effective user flag. A violation ends with `fault_prot = 1` and no writeback. Otherwise the effective flags appear on `fill_writable` and `fill_user`.
- R7: On a successful walk, every entry used whose accessed flag (bit 5) is clear is rewritten with that bit set and all other bits unchanged. A walk that faults writes nothing.
- R8: On a write access, the leaf entry's dirty flag (bit 6) is set in memory if it was clear, and `fill_dirty` is 1. On a read access, `fill_dirty` equals the leaf entry's bit 6.
- R9: No memory write is made for a flag that is already set.
- R10: A miss presented while `busy` is high is ignored.
- R11: While a request waits for its acknowledge, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R12: `fill_global` equals bit 8 of the leaf entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_frame | input | 20 | Physical frame number of the directory page |
| miss_valid | input | 1 | Miss request, accepted when `busy` is low |
| miss_va | input | 32 | Virtual address that missed |
| miss_write | input | 1 | The access is a write |
| miss_user | input | 1 | The access comes from user mode |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry for a write |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| fill_valid | output | 1 | One-cycle pulse: translation ready |
| fill_vpn | output | 20 | Virtual page number of the translation |
| fill_pa | output | 32 | Physical address of the access |
| fill_large | output | 1 | The mapping is a 4 MB page |
| fill_writable | output | 1 | Effective writable flag |
| fill_user | output | 1 | Effective user flag |
| fill_global | output | 1 | Global flag of the leaf entry |
| fill_dirty | output | 1 | Leaf is dirty after this access |
| fault_valid | output | 1 | One-cycle pulse: walk faulted |
| fault_va | output | 32 | Faulting virtual address |
| fault_prot | output | 1 | 1 = protection violation, 0 = entry not present |
| fault_write | output | 1 | The faulting access was a write |
| fault_user | output | 1 | The faulting access came from user mode |

## Verification
On every cycle, the assertions check the following:
- the memory handshake stays stable while a request waits;
- every write to memory carries the accessed flag;
- the walker is quiet when idle and drops `busy` after each result;
- the page offset passes through unchanged into `fill_pa`;
- a fill never grants less permission than the access needed, and is dirty for a write;
- a fault reports the address and access type that were accepted.

Other behaviour shows only in the directed scenarios, which compare memory contents and transaction counts with values worked out from the entry layouts:
- the computed entry addresses;
- which entries get rewritten, and the skipped writebacks;
- the order in which the fault causes are judged;
- the large-page path without a second read;
- a miss ignored while a walk is in progress.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned ENT_B   = 2;
  localparam int unsigned PFN_W   = AW - OFS_W;
  localparam int unsigned BIG_OFS = OFS_W + IDX_W;

  // entry flag positions (decoded by software, so fixed)
  localparam int unsigned F_PRES  = 0;
  localparam int unsigned F_WR    = 1;
  localparam int unsigned F_USR   = 2;
  localparam int unsigned F_ACC   = 5;
  localparam int unsigned F_DIRTY = 6;
  localparam int unsigned F_BIG   = 7;
  localparam int unsigned F_GLB   = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_WB, ST_DONE, ST_FAULT
  } walk_state_t;

  function automatic logic [AW-1:0] dir_entry_addr(input logic [PFN_W-1:0] frame,
                                                   input logic [AW-1:0] va);
    return {frame, va[AW-1:BIG_OFS], {ENT_B{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] tbl_entry_addr(input logic [PFN_W-1:0] frame,
                                                   input logic [AW-1:0] va);
    return {frame, va[BIG_OFS-1:OFS_W], {ENT_B{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] small_pa(input logic [PFN_W-1:0] frame,
                                             input logic [AW-1:0] va);
    return {frame, va[OFS_W-1:0]};
  endfunction

  function automatic logic [AW-1:0] big_pa(input logic [PFN_W-1:0] frame,
                                           input logic [AW-1:0] va);
    return {frame[PFN_W-1:IDX_W], va[BIG_OFS-1:0]};
  endfunction

  function automatic logic leaf_needs_wb(input logic [AW-1:0] e, input logic wr);
    return !e[F_ACC] || (wr && !e[F_DIRTY]);
  endfunction

  function automatic logic [AW-1:0] mark_entry(input logic [AW-1:0] e, input logic set_d);
    logic [AW-1:0] r;
    r = e;
    r[F_ACC] = 1'b1;
    if (set_d) r[F_DIRTY] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/walk_addr.sv
module walk_addr
  import walk_pkg::*;
(
  input  logic [PFN_W-1:0] dir_frame,
  input  logic [AW-1:0]    va,
  input  logic [PFN_W-1:0] dir_next,
  input  logic [PFN_W-1:0] leaf_frame,
  output logic [AW-1:0]    dir_addr,
  output logic [AW-1:0]    tbl_addr,
  output logic [AW-1:0]    pa_small,
  output logic [AW-1:0]    pa_big
);
  always_comb begin
    dir_addr = dir_entry_addr(dir_frame, va);
    tbl_addr = tbl_entry_addr(dir_next, va);
    pa_small = small_pa(leaf_frame, va);
    pa_big   = big_pa(dir_next, va);
  end
endmodule

// File: rtl/walk_perm.sv
module walk_perm (
  input  logic big,
  input  logic dir_wr,
  input  logic dir_usr,
  input  logic leaf_wr,
  input  logic leaf_usr,
  input  logic acc_wr,
  input  logic acc_usr,
  output logic eff_wr,
  output logic eff_usr,
  output logic prot_bad
);
  always_comb begin
    eff_wr   = big ? dir_wr  : (dir_wr  & leaf_wr);
    eff_usr  = big ? dir_usr : (dir_usr & leaf_usr);
    prot_bad = (acc_wr & ~eff_wr) | (acc_usr & ~eff_usr);
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PFN_W-1:0] dir_frame,
  input  logic             miss_valid,
  input  logic [AW-1:0]    miss_va,
  input  logic             miss_write,
  input  logic             miss_user,
  output logic             busy,
  output logic             accept,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata,
  output logic [PFN_W-1:0] base_q_o,
  output logic [AW-1:0]    va_q_o,
  output logic [PFN_W-1:0] dir_next_o,
  output logic [PFN_W-1:0] leaf_frame_o,
  input  logic [AW-1:0]    dir_addr,
  input  logic [AW-1:0]    tbl_addr,
  input  logic [AW-1:0]    pa_small,
  input  logic [AW-1:0]    pa_big,
  output logic             perm_big,
  output logic             perm_dir_wr,
  output logic             perm_dir_usr,
  output logic             perm_leaf_wr,
  output logic             perm_leaf_usr,
  output logic             acc_wr,
  output logic             acc_usr,
  input  logic             eff_wr,
  input  logic             eff_usr,
  input  logic             prot_bad,
  output logic             fill_valid,
  output logic [PFN_W-1:0] fill_vpn,
  output logic [AW-1:0]    fill_pa,
  output logic             fill_large,
  output logic             fill_writable,
  output logic             fill_user,
  output logic             fill_global,
  output logic             fill_dirty,
  output logic             fault_valid,
  output logic [AW-1:0]    fault_va,
  output logic             fault_prot,
  output logic             fault_write,
  output logic             fault_user
);
  walk_state_t      state_q, state_d;
  logic [PFN_W-1:0] base_q;
  logic [AW-1:0]    va_q, pde_q, pte_q;
  logic             wr_q, us_q, big_q, prot_q;
  logic             wb_dir_q, wb_leaf_q;
  logic             eff_wr_q, eff_usr_q;
  logic             rd_hs;
  logic             ent_present, ent_big;

  assign busy        = (state_q != ST_IDLE);
  assign accept      = miss_valid && (state_q == ST_IDLE);
  assign rd_hs       = mem_ack && ((state_q == ST_RD_DIR) || (state_q == ST_RD_TBL));
  assign ent_present = mem_rdata[F_PRES];
  assign ent_big     = mem_rdata[F_BIG];

  // permission inputs: live entry in the read cycle, held directory entry later
  assign perm_big      = (state_q == ST_RD_DIR);
  assign perm_dir_wr   = (state_q == ST_RD_DIR) ? mem_rdata[F_WR]  : pde_q[F_WR];
  assign perm_dir_usr  = (state_q == ST_RD_DIR) ? mem_rdata[F_USR] : pde_q[F_USR];
  assign perm_leaf_wr  = mem_rdata[F_WR];
  assign perm_leaf_usr = mem_rdata[F_USR];
  assign acc_wr        = wr_q;
  assign acc_usr       = us_q;

  assign base_q_o     = base_q;
  assign va_q_o       = va_q;
  assign dir_next_o   = pde_q[AW-1:OFS_W];
  assign leaf_frame_o = pte_q[AW-1:OFS_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (miss_valid) state_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_ack) begin
        if (!ent_present)   state_d = ST_FAULT;
        else if (ent_big)   state_d = prot_bad ? ST_FAULT :
                                      (leaf_needs_wb(mem_rdata, wr_q) ? ST_WB : ST_DONE);
        else                state_d = ST_RD_TBL;
      end
      ST_RD_TBL: if (mem_ack) begin
        if (!ent_present || prot_bad) state_d = ST_FAULT;
        else if (!pde_q[F_ACC] || leaf_needs_wb(mem_rdata, wr_q)) state_d = ST_WB;
        else state_d = ST_DONE;
      end
      ST_WB:     if (mem_ack && !(wb_dir_q && wb_leaf_q)) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      ST_FAULT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      va_q      <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      wr_q      <= 1'b0;
      us_q      <= 1'b0;
      big_q     <= 1'b0;
      prot_q    <= 1'b0;
      wb_dir_q  <= 1'b0;
      wb_leaf_q <= 1'b0;
      eff_wr_q  <= 1'b0;
      eff_usr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        base_q <= dir_frame;
        va_q   <= miss_va;
        wr_q   <= miss_write;
        us_q   <= miss_user;
        big_q  <= 1'b0;
      end
      if (rd_hs) begin
        eff_wr_q  <= eff_wr;
        eff_usr_q <= eff_usr;
      end
      if (rd_hs && (state_q == ST_RD_DIR)) begin
        pde_q     <= mem_rdata;
        big_q     <= ent_present && ent_big;
        prot_q    <= ent_present;
        wb_dir_q  <= ent_present && ent_big && leaf_needs_wb(mem_rdata, wr_q);
        wb_leaf_q <= 1'b0;
      end
      if (rd_hs && (state_q == ST_RD_TBL)) begin
        pte_q     <= mem_rdata;
        prot_q    <= ent_present;
        wb_dir_q  <= !pde_q[F_ACC];
        wb_leaf_q <= leaf_needs_wb(mem_rdata, wr_q);
      end
      if (mem_ack && (state_q == ST_WB)) begin
        if (wb_dir_q) wb_dir_q  <= 1'b0;
        else          wb_leaf_q <= 1'b0;
      end
    end
  end

  always_comb begin
    mem_req   = (state_q == ST_RD_DIR) || (state_q == ST_RD_TBL) || (state_q == ST_WB);
    mem_we    = (state_q == ST_WB);
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD_DIR: mem_addr = dir_addr;
      ST_RD_TBL: mem_addr = tbl_addr;
      ST_WB: begin
        mem_addr  = wb_dir_q ? dir_addr : tbl_addr;
        mem_wdata = wb_dir_q ? mark_entry(pde_q, big_q && wr_q) : mark_entry(pte_q, wr_q);
      end
      default: ;
    endcase
  end

  assign fill_valid    = (state_q == ST_DONE);
  assign fill_vpn      = va_q[AW-1:OFS_W];
  assign fill_pa       = big_q ? pa_big : pa_small;
  assign fill_large    = big_q;
  assign fill_writable = eff_wr_q;
  assign fill_user     = eff_usr_q;
  assign fill_global   = big_q ? pde_q[F_GLB] : pte_q[F_GLB];
  assign fill_dirty    = (big_q ? pde_q[F_DIRTY] : pte_q[F_DIRTY]) | wr_q;
  assign fault_valid   = (state_q == ST_FAULT);
  assign fault_va      = va_q;
  assign fault_prot    = prot_q;
  assign fault_write   = wr_q;
  assign fault_user    = us_q;
endmodule

// File: rtl/tlb_miss_walker.sv
module tlb_miss_walker
  import walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PFN_W-1:0] dir_frame,
  input  logic             miss_valid,
  input  logic [AW-1:0]    miss_va,
  input  logic             miss_write,
  input  logic             miss_user,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [AW-1:0]    mem_rdata,
  output logic             fill_valid,
  output logic [PFN_W-1:0] fill_vpn,
  output logic [AW-1:0]    fill_pa,
  output logic             fill_large,
  output logic             fill_writable,
  output logic             fill_user,
  output logic             fill_global,
  output logic             fill_dirty,
  output logic             fault_valid,
  output logic [AW-1:0]    fault_va,
  output logic             fault_prot,
  output logic             fault_write,
  output logic             fault_user
);
  logic             accept;
  logic [PFN_W-1:0] base_q, dir_next, leaf_frame;
  logic [AW-1:0]    va_q, dir_addr, tbl_addr, pa_small, pa_big;
  logic             perm_big, perm_dir_wr, perm_dir_usr, perm_leaf_wr, perm_leaf_usr;
  logic             acc_wr, acc_usr, eff_wr, eff_usr, prot_bad;

  walk_ctrl u_ctrl (
    .clk, .rst_n, .dir_frame, .miss_valid, .miss_va, .miss_write, .miss_user,
    .busy, .accept, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .base_q_o(base_q), .va_q_o(va_q), .dir_next_o(dir_next), .leaf_frame_o(leaf_frame),
    .dir_addr, .tbl_addr, .pa_small, .pa_big,
    .perm_big, .perm_dir_wr, .perm_dir_usr, .perm_leaf_wr, .perm_leaf_usr,
    .acc_wr, .acc_usr, .eff_wr, .eff_usr, .prot_bad,
    .fill_valid, .fill_vpn, .fill_pa, .fill_large, .fill_writable, .fill_user,
    .fill_global, .fill_dirty, .fault_valid, .fault_va, .fault_prot, .fault_write,
    .fault_user
  );

  walk_addr u_addr (
    .dir_frame(base_q), .va(va_q), .dir_next, .leaf_frame,
    .dir_addr, .tbl_addr, .pa_small, .pa_big
  );

  walk_perm u_perm (
    .big(perm_big), .dir_wr(perm_dir_wr), .dir_usr(perm_dir_usr),
    .leaf_wr(perm_leaf_wr), .leaf_usr(perm_leaf_usr),
    .acc_wr, .acc_usr, .eff_wr, .eff_usr, .prot_bad
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic [31:0] miss_va,
  input logic        miss_write,
  input logic        miss_user,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        fill_valid,
  input logic [21:0] fill_off,
  input logic        fill_large,
  input logic        fill_writable,
  input logic        fill_user,
  input logic        fill_dirty,
  input logic        fault_valid,
  input logic [31:0] fault_va,
  input logic        fault_write,
  input logic        fault_user
);
  logic [31:0] l_va;
  logic        l_wr, l_us;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_va <= '0; l_wr <= 1'b0; l_us <= 1'b0;
    end else if (accept) begin
      l_va <= miss_va; l_wr <= miss_write; l_us <= miss_user;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !fill_valid && !fault_valid));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_wb_marks_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);

  assert_small_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_large) |-> (fill_off[11:0] == l_va[11:0]));

  assert_big_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_large) |-> (fill_off == l_va[21:0]));

  assert_fill_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> ((!l_wr || fill_writable) && (!l_us || fill_user)));

  assert_write_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && l_wr) |-> fill_dirty);

  assert_fault_info_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (fault_va == l_va && fault_write == l_wr && fault_user == l_us));

  assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || fault_valid) |=> !busy);
endmodule

bind tlb_miss_walker walk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .miss_va(miss_va),
  .miss_write(miss_write), .miss_user(miss_user), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .fill_valid(fill_valid), .fill_off(fill_pa[21:0]),
  .fill_large(fill_large), .fill_writable(fill_writable), .fill_user(fill_user),
  .fill_dirty(fill_dirty), .fault_valid(fault_valid), .fault_va(fault_va),
  .fault_write(fault_write), .fault_user(fault_user)
);

// File: tb/tlb_miss_walker_tb.sv
`timescale 1ns/1ps
module tlb_miss_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] dir_frame = 20'h00100;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_va = '0;
  logic        miss_write = 1'b0, miss_user = 1'b0;
  logic        busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        fill_valid, fill_large, fill_writable, fill_user, fill_global, fill_dirty;
  logic [19:0] fill_vpn;
  logic [31:0] fill_pa, fault_va;
  logic        fault_valid, fault_prot, fault_write, fault_user;

  always #2 clk = ~clk;

  tlb_miss_walker u_dut (
    .clk, .rst_n, .dir_frame, .miss_valid, .miss_va, .miss_write, .miss_user, .busy,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .fill_valid, .fill_vpn, .fill_pa, .fill_large, .fill_writable, .fill_user,
    .fill_global, .fill_dirty, .fault_valid, .fault_va, .fault_prot, .fault_write,
    .fault_user
  );

  // memory model: ack one cycle after request, preload port for the bench
  logic [31:0] mem [logic [31:0]];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        pk_en = 1'b0;
  logic [31:0] pk_addr = '0, pk_data = '0;

  always @(posedge clk) begin
    if (pk_en) mem[pk_addr] = pk_data;
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        rd_cnt++;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  int total = 0, bad = 0;
  logic r_fill, r_fault, r_large, r_wr, r_us, r_glb, r_dirty, r_prot, r_fw, r_fu;
  logic [19:0] r_vpn;
  logic [31:0] r_pa, r_fva;
  int rd0, wr0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] dir_slot(input logic [31:0] va);
    return ({12'h0, dir_frame} << 12) + ((va >> 22) << 2);
  endfunction

  function automatic logic [31:0] tbl_slot(input logic [31:0] pde, input logic [31:0] va);
    return (pde & 32'hFFFF_F000) + (((va >> 12) & 32'h3FF) * 4);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pk_en = 1'b1; pk_addr = a; pk_data = d;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic wait_result();
    r_fill = 1'b0; r_fault = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (fill_valid) begin
        r_fill = 1'b1; r_pa = fill_pa; r_vpn = fill_vpn; r_large = fill_large;
        r_wr = fill_writable; r_us = fill_user; r_glb = fill_global; r_dirty = fill_dirty;
        break;
      end
      if (fault_valid) begin
        r_fault = 1'b1; r_fva = fault_va; r_prot = fault_prot;
        r_fw = fault_write; r_fu = fault_user;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic walk(input logic [31:0] va, input logic w, input logic u);
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    miss_va = va; miss_write = w; miss_user = u; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    wait_result();
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", {31'h0, busy}, 32'h0);
    chk("R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);
    chk("R1", "fill after reset", {31'h0, fill_valid}, 32'h0);
    chk("R1", "fault after reset", {31'h0, fault_valid}, 32'h0);
  endtask

  task automatic t_small_read();
    logic [31:0] va = 32'h1234_5678, pde = 32'h0020_0007, pte = 32'hABCD_E107;
    poke(dir_slot(va), pde);
    poke(tbl_slot(pde, va), pte);
    walk(va, 1'b0, 1'b1);
    chk("R3", "fill seen", {31'h0, r_fill}, 32'h1);
    chk("R3", "pa", r_pa, (pte & 32'hFFFF_F000) | (va & 32'hFFF));
    chk("R3", "vpn", {12'h0, r_vpn}, va >> 12);
    chk("R3", "large", {31'h0, r_large}, 32'h0);
    chk("R2", "two reads", rd_cnt - rd0, 2);
    chk("R7", "two A writebacks", wr_cnt - wr0, 2);
    chk("R7", "dir entry A", peek(dir_slot(va)), pde | 32'h20);
    chk("R8", "leaf A only on read", peek(tbl_slot(pde, va)), pte | 32'h20);
    chk("R8", "read not dirty", {31'h0, r_dirty}, 32'h0);
    chk("R12", "global", {31'h0, r_glb}, 32'h1);
    chk("R6", "writable+user", {30'h0, r_wr, r_us}, 32'h3);
  endtask

  task automatic t_small_write();
    logic [31:0] va = 32'h0040_3ABC, pde = 32'h0030_0023, pte = 32'h5555_5023;
    poke(dir_slot(va), pde);
    poke(tbl_slot(pde, va), pte);
    walk(va, 1'b1, 1'b0);
    chk("R3", "write pa", r_pa, (pte & 32'hFFFF_F000) | (va & 32'hFFF));
    chk("R8", "D set in leaf", peek(tbl_slot(pde, va)), pte | 32'h40);
    chk("R9", "dir untouched", peek(dir_slot(va)), pde);
    chk("R9", "one write", wr_cnt - wr0, 1);
    chk("R8", "fill dirty", {31'h0, r_dirty}, 32'h1);
    chk("R6", "user denied at dir", {31'h0, r_us}, 32'h0);
    chk("R12", "not global", {31'h0, r_glb}, 32'h0);
    walk(va, 1'b0, 1'b0);
    chk("R9", "no writes when flags set", wr_cnt - wr0, 0);
    chk("R8", "read of dirty leaf", {31'h0, r_dirty}, 32'h1);
  endtask

  task automatic t_large();
    logic [31:0] va = 32'h8765_4321, pde = 32'h4AC0_0183;
    poke(dir_slot(va), pde);
    walk(va, 1'b1, 1'b0);
    chk("R4", "fill seen", {31'h0, r_fill}, 32'h1);
    chk("R4", "pa", r_pa, (pde & 32'hFFC0_0000) | (va & 32'h003F_FFFF));
    chk("R4", "large flag", {31'h0, r_large}, 32'h1);
    chk("R4", "single read", rd_cnt - rd0, 1);
    chk("R8", "dir A and D", peek(dir_slot(va)), pde | 32'h60);
    chk("R12", "global from dir", {31'h0, r_glb}, 32'h1);
  endtask

  task automatic t_dir_absent();
    logic [31:0] va = 32'hC000_1000;
    walk(va, 1'b1, 1'b1);
    chk("R5", "fault seen", {31'h0, r_fault}, 32'h1);
    chk("R5", "cause absent", {31'h0, r_prot}, 32'h0);
    chk("R5", "fault va", r_fva, va);
    chk("R5", "write+user", {30'h0, r_fw, r_fu}, 32'h3);
    chk("R5", "no table read", rd_cnt - rd0, 1);
    chk("R7", "no writes", wr_cnt - wr0, 0);
  endtask

  task automatic t_tbl_absent();
    logic [31:0] va = 32'h0080_5000, pde = 32'h0040_0007;
    poke(dir_slot(va), pde);
    walk(va, 1'b0, 1'b0);
    chk("R5", "leaf absent fault", {30'h0, r_fault, r_prot}, 32'h2);
    chk("R5", "read/super", {30'h0, r_fw, r_fu}, 32'h0);
    chk("R7", "dir not marked on fault", peek(dir_slot(va)), pde);
    chk("R7", "no writes", wr_cnt - wr0, 0);
  endtask

  task automatic t_prot();
    logic [31:0] va1 = 32'h00C0_6000, pde1 = 32'h0050_0003, pte1 = 32'h6666_6007;
    logic [31:0] va2 = 32'h0100_7000, pde2 = 32'h0060_0027, pte2 = 32'h7777_7025;
    poke(dir_slot(va1), pde1);
    poke(tbl_slot(pde1, va1), pte1);
    walk(va1, 1'b0, 1'b1);
    chk("R6", "user blocked at dir", {30'h0, r_fault, r_prot}, 32'h3);
    chk("R6", "no writes", wr_cnt - wr0, 0);
    poke(dir_slot(va2), pde2);
    poke(tbl_slot(pde2, va2), pte2);
    walk(va2, 1'b1, 1'b0);
    chk("R6", "write blocked at leaf", {30'h0, r_fault, r_prot}, 32'h3);
    chk("R6", "leaf unchanged", peek(tbl_slot(pde2, va2)), pte2);
    walk(va2, 1'b0, 1'b0);
    chk("R6", "super read ok", {31'h0, r_fill}, 32'h1);
    chk("R6", "eff writable 0 user 1", {30'h0, r_wr, r_us}, 32'h1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] va = 32'h1234_5678;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    miss_va = va; miss_write = 1'b0; miss_user = 1'b0; miss_valid = 1'b1;
    @(negedge clk);
    miss_va = 32'hC000_1000; miss_write = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    wait_result();
    chk("R10", "first miss served", {12'h0, r_vpn}, va >> 12);
    repeat (10) @(negedge clk);
    chk("R10", "idle afterwards", {31'h0, busy}, 32'h0);
    chk("R10", "only one walk", rd_cnt - rd0, 2);
  endtask

  initial begin
    logic timeout;
    timeout = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_small_read();
        t_small_write();
        t_large();
        t_dir_absent();
        t_tbl_absent();
        t_prot();
        t_busy_ignore();
      end
      begin
        repeat (50000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule